// File: doc/BRIEF.md
# Page-Splitting Block-Transfer DMA Engine

This engine moves a block of words between one peripheral and memory with no processor work once the move has begun. Software writes a byte start address and a word count into their configuration slots. It then writes a command word that carries the direction and a go bit. From that point the engine owns the memory bus. It paces every word with a valid/ready handshake toward the peripheral and with request/grant and valid/ready toward memory.

A block that crosses a page boundary is never issued as one burst. The engine cuts the block into chained bursts, each kept inside a single page. Each burst sends one address phase that carries its length, followed by back-to-back data beats. The bus stays locked until the burst's final beat. The peripheral and memory data paths are joined with no staging register, so a stall on either side holds the word in place. When the last word has moved, the engine gives a one-cycle interrupt and records completion in its status outputs.

Top module: `blk_dma`

## Requirements
- R1: After reset the following outputs are all low: stat_busy, stat_done, stat_err, irq, mem_req, mem_lock, mem_wvalid, mem_rready, dev_rready and dev_wvalid.
- R2: Writes with cfg_we select a slot through cfg_sel. Slot 0 is the byte address, with the low two bits ignored so the address is word aligned. Slot 1 is the word count. Slot 2 is the command: bit 0 is go, and bit 1 is the direction (0 = peripheral-to-memory, 1 = memory-to-peripheral). An accepted go makes stat_busy high in the next cycle.
- R3: Each burst opens with mem_req and presents mem_addr, mem_len and mem_we (1 for peripheral-to-memory). These stay steady until mem_gnt, and each burst has exactly one address phase.
- R4: The burst length is the smaller of two values: the words still to move, and the words left before the next PAGE_BYTES boundary. No burst crosses a page.
- R5: Bursts chain automatically at consecutive addresses, and their lengths add up to the programmed count.
- R6: Peripheral-to-memory: a word moves when dev_rvalid and mem_wready are both high. mem_wdata equals dev_rdata, and mem_wlast marks the last word of each burst. A deasserted ready loses no word.
- R7: Memory-to-peripheral: a word moves when mem_rvalid and dev_wready are both high, and dev_wdata equals mem_rdata.
- R8: mem_lock is high from the address phase through the last beat of every burst.
- R9: After the final word, irq is high for exactly one cycle. The next cycle shows stat_busy low and stat_done high.
- R10: An accepted go clears stat_done.
- R11: A go written while busy is ignored and sets stat_err. The next accepted go clears stat_err.
- R12: A go with count 0 produces no memory request and still gives irq and stat_done.
- R13: Address or count writes made while busy do not alter the running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Slot select: 0 address, 1 count, 2 command |
| cfg_wdata | input | ADDR_W | Configuration write data |
| stat_busy | output | 1 | Transfer in progress |
| stat_done | output | 1 | Last transfer completed |
| stat_err | output | 1 | Go written while busy |
| irq | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Burst address phase request |
| mem_addr | output | ADDR_W | Burst start byte address |
| mem_we | output | 1 | 1 = write burst into memory |
| mem_len | output | LEN_W | Burst length in words |
| mem_gnt | input | 1 | Address phase accepted |
| mem_lock | output | 1 | Bus held for the current burst |
| mem_wvalid | output | 1 | Write data valid |
| mem_wdata | output | DATA_W | Write data |
| mem_wlast | output | 1 | Last write beat of burst |
| mem_wready | input | 1 | Memory accepts write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DATA_W | Read data |
| mem_rready | output | 1 | Engine accepts read data |
| dev_rvalid | input | 1 | Peripheral offers a word |
| dev_rdata | input | DATA_W | Word from peripheral |
| dev_rready | output | 1 | Engine takes peripheral word |
| dev_wvalid | output | 1 | Word offered to peripheral |
| dev_wdata | output | DATA_W | Word to peripheral |
| dev_wready | input | 1 | Peripheral takes the word |

## Verification
Two situations are hard to reach from the ports. The first is a burst that ends exactly where a page ends; the second is a block that spans three pages, so a full-page burst sits between two partial ones. The stimulus reaches both by choosing start addresses just below and exactly on page boundaries, with counts sized to land at those edges. Misuse while a transfer runs is the other corner. The bench writes a new address, a new count and a second go in the middle of a long transfer. It then confirms that the error flag rises and that every burst header and data word still matches the original program. Throughout, grant and both ready signals follow staggered patterns, so stalls land at the first beat, in the middle and at the last beat of bursts.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_FIN  = 2'd3
  } dma_state_e;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_CNT  = 2'd1;
  localparam logic [1:0] SEL_CMD  = 2'd2;
endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int WB_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              busy,
  input  logic              finish,
  output logic [ADDR_W-1:0] base_addr,
  output logic [CNT_W-1:0]  word_cnt,
  output logic              dir_m2d,
  output logic              start_acc,
  output logic              done,
  output logic              err
);
  logic [ADDR_W-1:0] base_q, base_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              dir_q, dir_n, done_q, done_n, err_q, err_n;
  logic              go_req, go_rej;

  always_comb begin
    go_req    = cfg_we && (cfg_sel == SEL_CMD) && cfg_wdata[0];
    start_acc = go_req && !busy;
    go_rej    = go_req && busy;
    base_n = base_q;
    cnt_n  = cnt_q;
    dir_n  = dir_q;
    done_n = done_q;
    err_n  = err_q;
    if (cfg_we && cfg_sel == SEL_ADDR)
      base_n = {cfg_wdata[ADDR_W-1:WB_W], {WB_W{1'b0}}};
    if (cfg_we && cfg_sel == SEL_CNT)
      cnt_n = cfg_wdata[CNT_W-1:0];
    if (start_acc) begin
      dir_n  = cfg_wdata[1];
      done_n = 1'b0;
      err_n  = 1'b0;
    end
    if (go_rej)  err_n  = 1'b1;
    if (finish)  done_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      dir_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      base_q <= base_n;
      cnt_q  <= cnt_n;
      dir_q  <= dir_n;
      done_q <= done_n;
      err_q  <= err_n;
    end
  end

  assign base_addr = base_q;
  assign word_cnt  = cnt_q;
  assign dir_m2d   = dir_q;
  assign done      = done_q;
  assign err       = err_q;
endmodule

// File: rtl/dma_burst_calc.sv
module dma_burst_calc #(
  parameter int CNT_W      = 16,
  parameter int PAGE_WORDS = 1024,
  parameter int OFF_W      = 10,
  parameter int LEN_W      = 11
) (
  input  logic [OFF_W-1:0] page_off,
  input  logic [CNT_W-1:0] remaining,
  output logic [LEN_W-1:0] blen
);
  logic [LEN_W-1:0] room;

  always_comb begin
    room = LEN_W'(PAGE_WORDS) - LEN_W'(page_off);
    if (remaining < CNT_W'(room)) blen = LEN_W'(remaining);
    else                          blen = room;
  end
endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
  import dma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int LEN_W      = 11,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_acc,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [CNT_W-1:0]  word_cnt,
  input  logic [LEN_W-1:0]  blen,
  input  logic              mem_gnt,
  input  logic              beat,
  output dma_state_e        state,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [CNT_W-1:0]  remaining,
  output logic              last_beat
);
  dma_state_e        st_q, st_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [CNT_W-1:0]  rem_q, rem_n;
  logic [LEN_W-1:0]  beats_q, beats_n;
  logic              run_en;

  always_comb begin
    st_n    = st_q;
    addr_n  = addr_q;
    rem_n   = rem_q;
    beats_n = beats_q;
    case (st_q)
      ST_IDLE: if (start_acc) begin
        addr_n = base_addr;
        rem_n  = word_cnt;
        st_n   = (word_cnt == '0) ? ST_FIN : ST_ADDR;
      end
      ST_ADDR: if (mem_gnt) begin
        beats_n = blen;
        st_n    = ST_DATA;
      end
      ST_DATA: if (beat) begin
        addr_n  = addr_q + ADDR_W'(WORD_BYTES);
        rem_n   = rem_q - CNT_W'(1);
        beats_n = beats_q - LEN_W'(1);
        if (beats_q == LEN_W'(1))
          st_n = (rem_q == CNT_W'(1)) ? ST_FIN : ST_ADDR;
      end
      default: st_n = ST_IDLE;
    endcase
    run_en = (st_n != st_q) || (addr_n != addr_q) || (beats_n != beats_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      beats_q <= '0;
    end else if (run_en) begin
      st_q    <= st_n;
      addr_q  <= addr_n;
      rem_q   <= rem_n;
      beats_q <= beats_n;
    end
  end

  assign state     = st_q;
  assign cur_addr  = addr_q;
  assign remaining = rem_q;
  assign last_beat = (st_q == ST_DATA) && (beats_q == LEN_W'(1));
endmodule

// File: rtl/blk_dma.sv
module blk_dma
  import dma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 16,
  parameter int PAGE_BYTES = 4096,
  parameter int WORD_BYTES = 4,
  localparam int PAGE_WORDS = PAGE_BYTES / WORD_BYTES,
  localparam int LEN_W      = $clog2(PAGE_WORDS) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic              stat_busy,
  output logic              stat_done,
  output logic              stat_err,
  output logic              irq,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [LEN_W-1:0]  mem_len,
  input  logic              mem_gnt,
  output logic              mem_lock,
  output logic              mem_wvalid,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_wlast,
  input  logic              mem_wready,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_rready,
  input  logic              dev_rvalid,
  input  logic [DATA_W-1:0] dev_rdata,
  output logic              dev_rready,
  output logic              dev_wvalid,
  output logic [DATA_W-1:0] dev_wdata,
  input  logic              dev_wready
);
  localparam int WB_W  = $clog2(WORD_BYTES);
  localparam int PG_W  = $clog2(PAGE_BYTES);
  localparam int OFF_W = PG_W - WB_W;

  dma_state_e        state;
  logic [ADDR_W-1:0] base_addr, cur_addr;
  logic [CNT_W-1:0]  word_cnt, remaining;
  logic [LEN_W-1:0]  blen;
  logic              dir_m2d, start_acc, last_beat, beat, in_data, busy, finish;

  assign busy   = (state != ST_IDLE);
  assign finish = (state == ST_FIN);

  dma_cfg_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .WB_W(WB_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .busy(busy), .finish(finish),
    .base_addr(base_addr), .word_cnt(word_cnt), .dir_m2d(dir_m2d),
    .start_acc(start_acc), .done(stat_done), .err(stat_err)
  );

  dma_burst_calc #(.CNT_W(CNT_W), .PAGE_WORDS(PAGE_WORDS), .OFF_W(OFF_W),
                   .LEN_W(LEN_W)) u_calc (
    .page_off(cur_addr[PG_W-1:WB_W]), .remaining(remaining), .blen(blen)
  );

  dma_xfer_fsm #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LEN_W(LEN_W),
                 .WORD_BYTES(WORD_BYTES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_acc(start_acc), .base_addr(base_addr),
    .word_cnt(word_cnt), .blen(blen), .mem_gnt(mem_gnt), .beat(beat),
    .state(state), .cur_addr(cur_addr), .remaining(remaining),
    .last_beat(last_beat)
  );

  assign in_data    = (state == ST_DATA);
  assign stat_busy  = busy;
  assign irq        = finish;
  assign mem_req    = (state == ST_ADDR);
  assign mem_addr   = cur_addr;
  assign mem_we     = !dir_m2d;
  assign mem_len    = blen;
  assign mem_lock   = (state == ST_ADDR) || in_data;

  assign mem_wvalid = in_data && !dir_m2d && dev_rvalid;
  assign mem_wdata  = dev_rdata;
  assign mem_wlast  = mem_wvalid && last_beat;
  assign dev_rready = in_data && !dir_m2d && mem_wready;

  assign dev_wvalid = in_data && dir_m2d && mem_rvalid;
  assign dev_wdata  = mem_rdata;
  assign mem_rready = in_data && dir_m2d && dev_wready;

  assign beat = dir_m2d ? (dev_wvalid && dev_wready) : (mem_wvalid && mem_wready);
endmodule

// File: rtl/dma_checker.sv
module dma_checker #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_BYTES = 4096,
  parameter int WORD_BYTES = 4,
  localparam int PAGE_WORDS = PAGE_BYTES / WORD_BYTES,
  localparam int LEN_W      = $clog2(PAGE_WORDS) + 1,
  localparam int WB_W       = $clog2(WORD_BYTES),
  localparam int PG_W       = $clog2(PAGE_BYTES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [1:0]        cfg_sel,
  input logic              cfg_go,
  input logic              stat_busy,
  input logic              stat_done,
  input logic              stat_err,
  input logic              irq,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [LEN_W-1:0]  mem_len,
  input logic              mem_gnt,
  input logic              mem_lock,
  input logic              mem_wvalid,
  input logic              mem_wlast,
  input logic              dev_wvalid
);
  logic [LEN_W:0] page_end;
  logic           go_wr;
  assign page_end = {1'b0, LEN_W'(mem_addr[PG_W-1:WB_W])} + {1'b0, mem_len};
  assign go_wr    = cfg_we && (cfg_sel == 2'd2) && cfg_go;

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_len));
  p_no_page_cross_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_len != '0) && (page_end <= (LEN_W+1)'(PAGE_WORDS)));
  p_wlast_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wlast |-> mem_wvalid);
  p_lock_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wvalid || dev_wvalid || mem_req) |-> mem_lock);
  p_irq_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq && !stat_busy && stat_done);
  p_go_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    go_wr && !stat_busy |=> stat_busy && !stat_done && !stat_err);
  p_busy_go_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
    go_wr && stat_busy |=> stat_err);
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_busy |-> !mem_req && !mem_lock && !irq);
endmodule

bind blk_dma dma_checker #(
  .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .WORD_BYTES(WORD_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .cfg_go(cfg_wdata[0]), .stat_busy(stat_busy), .stat_done(stat_done),
  .stat_err(stat_err), .irq(irq), .mem_req(mem_req), .mem_addr(mem_addr),
  .mem_len(mem_len), .mem_gnt(mem_gnt), .mem_lock(mem_lock),
  .mem_wvalid(mem_wvalid), .mem_wlast(mem_wlast), .dev_wvalid(dev_wvalid)
);

// File: tb/blk_dma_bench.sv
module blk_dma_bench;
  localparam int AW = 32, DW = 32, PB = 4096, WBY = 4;
  localparam int PW = PB / WBY;
  localparam int LW = $clog2(PW) + 1;

  logic clk, rst_n, cfg_we;
  logic [1:0] cfg_sel;
  logic [AW-1:0] cfg_wdata, mem_addr;
  logic stat_busy, stat_done, stat_err, irq, mem_req, mem_we, mem_gnt, mem_lock;
  logic [LW-1:0] mem_len;
  logic mem_wvalid, mem_wlast, mem_wready, mem_rvalid, mem_rready;
  logic [DW-1:0] mem_wdata, mem_rdata, dev_rdata, dev_wdata;
  logic dev_rvalid, dev_rready, dev_wvalid, dev_wready;

  blk_dma u_blk_dma (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .stat_busy(stat_busy), .stat_done(stat_done),
    .stat_err(stat_err), .irq(irq), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_len(mem_len), .mem_gnt(mem_gnt), .mem_lock(mem_lock),
    .mem_wvalid(mem_wvalid), .mem_wdata(mem_wdata), .mem_wlast(mem_wlast),
    .mem_wready(mem_wready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .mem_rready(mem_rready), .dev_rvalid(dev_rvalid), .dev_rdata(dev_rdata),
    .dev_rready(dev_rready), .dev_wvalid(dev_wvalid), .dev_wdata(dev_wdata),
    .dev_wready(dev_wready)
  );

  typedef struct { logic [AW-1:0] a; int l; logic we; } hdr_t;
  typedef struct { logic [DW-1:0] d; logic last; } wrd_t;
  hdr_t hq[$];
  wrd_t dq[$];

  int n_chk = 0, n_fail = 0, cyc = 0, src_idx = 0, exp_src = 0;
  logic [AW-1:0] rd_ptr = '0;
  bit ended = 0;

  function automatic logic [DW-1:0] src_word(int i);
    return 32'hC0DE_0000 + DW'(i * 7);
  endfunction
  function automatic logic [DW-1:0] mem_word(logic [AW-1:0] a);
    return a ^ 32'h5A5A_0000;
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    clk = 0;
    forever #10 clk = ~clk;
  end

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  // bus responders: staggered grant/ready/valid patterns
  initial begin
    mem_gnt = 0; mem_wready = 0; dev_rvalid = 0; mem_rvalid = 0; dev_wready = 0;
    dev_rdata = '0; mem_rdata = '0;
    forever begin
      @(negedge clk); #1;
      cyc++;
      mem_gnt    = mem_req && (cyc % 3 != 2);
      mem_wready = (cyc % 4 != 1);
      dev_rvalid = (cyc % 5 != 3);
      dev_rdata  = src_word(src_idx);
      mem_rvalid = (cyc % 3 != 0);
      mem_rdata  = mem_word(rd_ptr);
      dev_wready = (cyc % 4 != 2);
    end
  end

  // monitor: pops scoreboard as bursts and beats appear
  initial begin
    forever begin
      @(negedge clk); #5;
      if (rst_n) begin
        if (mem_req && mem_gnt) begin
          if (hq.size() == 0) check(0, "R12", "unexpected burst addr", 64'(mem_addr), 0);
          else begin
            hdr_t h;
            h = hq.pop_front();
            check(mem_addr == h.a, "R5", "burst address", 64'(mem_addr), 64'(h.a));
            check(int'(mem_len) == h.l, "R4", "burst length", 64'(mem_len), 64'(h.l));
            check(mem_we == h.we, "R3", "burst direction", 64'(mem_we), 64'(h.we));
          end
          rd_ptr = mem_addr;
        end
        if (mem_wvalid && mem_wready) begin
          check(mem_lock, "R8", "lock during write beat", 64'(mem_lock), 1);
          if (dq.size() == 0) check(0, "R6", "unexpected write beat", 64'(mem_wdata), 0);
          else begin
            wrd_t w;
            w = dq.pop_front();
            check(mem_wdata == w.d, "R6", "write data", 64'(mem_wdata), 64'(w.d));
            check(mem_wlast == w.last, "R6", "write last", 64'(mem_wlast), 64'(w.last));
          end
        end
        if (dev_rvalid && dev_rready) src_idx++;
        if (dev_wvalid && dev_wready) begin
          check(mem_lock, "R8", "lock during read beat", 64'(mem_lock), 1);
          if (dq.size() == 0) check(0, "R7", "unexpected device word", 64'(dev_wdata), 0);
          else begin
            wrd_t w;
            w = dq.pop_front();
            check(dev_wdata == w.d, "R7", "device data", 64'(dev_wdata), 64'(w.d));
          end
          rd_ptr = rd_ptr + AW'(WBY);
        end
      end
    end
  end

  task automatic cfg_write(logic [1:0] sel, logic [AW-1:0] val);
    @(negedge clk); #1;
    cfg_we = 1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic push_expect(logic [AW-1:0] addr, int cnt, bit m2d);
    logic [AW-1:0] a;
    int rem;
    a = {addr[AW-1:2], 2'b00};
    rem = cnt;
    while (rem > 0) begin
      int room, l;
      room = PW - int'(a[11:2]);
      l = (rem < room) ? rem : room;
      hq.push_back('{a, l, !m2d});
      for (int i = 0; i < l; i++) begin
        if (m2d) dq.push_back('{mem_word(a + AW'(4 * i)), i == l - 1});
        else begin
          dq.push_back('{src_word(exp_src), i == l - 1});
          exp_src++;
        end
      end
      a = a + AW'(4 * l);
      rem -= l;
    end
  endtask

  task automatic start_xfer(logic [AW-1:0] addr, int cnt, bit m2d);
    push_expect(addr, cnt, m2d);
    cfg_write(2'd0, addr);
    cfg_write(2'd1, AW'(cnt));
    cfg_write(2'd2, {30'd0, m2d, 1'b1});
    #4;
    check(stat_busy, "R2", "busy after go", 64'(stat_busy), 1);
    check(!stat_done, "R10", "done cleared by go", 64'(stat_done), 0);
    check(!stat_err, "R11", "err cleared by go", 64'(stat_err), 0);
  endtask

  task automatic wait_done(string tag);
    while (!irq) begin @(negedge clk); #5; end
    @(negedge clk); #5;
    check(!irq, "R9", {tag, " irq single cycle"}, 64'(irq), 0);
    check(!stat_busy, "R9", {tag, " busy dropped"}, 64'(stat_busy), 0);
    check(stat_done, "R9", {tag, " done set"}, 64'(stat_done), 1);
    check(hq.size() == 0, "R5", {tag, " all bursts seen"}, 64'(hq.size()), 0);
    check(dq.size() == 0, "R5", {tag, " all words moved"}, 64'(dq.size()), 0);
  endtask

  initial begin
    rst_n = 0; cfg_we = 0; cfg_sel = '0; cfg_wdata = '0;
    repeat (4) @(negedge clk);
    #5;
    check(!stat_busy && !stat_done && !stat_err && !irq, "R1", "status after reset",
          {stat_busy, stat_done, stat_err, irq}, 0);
    check(!mem_req && !mem_lock && !mem_wvalid && !mem_rready && !dev_rready && !dev_wvalid,
          "R1", "bus outputs after reset",
          {mem_req, mem_lock, mem_wvalid, mem_rready, dev_rready, dev_wvalid}, 0);
    @(negedge clk); #1; rst_n = 1;

    start_xfer(32'h0000_0100, 8, 0);     wait_done("single burst R6");
    start_xfer(32'h0000_0FF0, 10, 0);    wait_done("page split R4");
    start_xfer(32'h0000_1FFC, 3, 1);     wait_done("read split R7");
    start_xfer(32'h0000_2F00, 1100, 1);  wait_done("three pages R5");
    start_xfer(32'h0000_3000, 1024, 0);  wait_done("exact page R4");
    start_xfer(32'h0000_6000, 0, 0);     wait_done("zero count R12");

    // misuse while busy (R11, R13)
    start_xfer(32'h0000_4000, 20, 0);
    cfg_write(2'd0, 32'h0000_9000);
    cfg_write(2'd1, 32'd3);
    cfg_write(2'd2, 32'h3);
    #4;
    check(stat_err, "R11", "err after go while busy", 64'(stat_err), 1);
    check(stat_busy, "R13", "transfer still running", 64'(stat_busy), 1);
    wait_done("unaltered R13");
    check(stat_err, "R11", "err holds until next go", 64'(stat_err), 1);

    start_xfer(32'h0000_5006, 2, 0);     wait_done("unaligned R2");
    finish_run();
  end
endmodule